// File: doc/BRIEF.md
# Looping Identification Frame Serializer

This block turns a 40-bit identifier into a fixed 64-bit identification frame and sends it out one bit at a time, forever. The frame starts with a run of nine ones. Ten rows follow, each holding four identifier bits and one row parity bit. Four column parity bits come next, and a single zero closes the frame. The block runs from the carrier-derived clock. Each frame bit is held for a data period of 64, 32 or 16 clock cycles, picked by a rate select. A single-cycle strobe marks the first cycle of every bit period, so that a downstream line encoder knows where each bit starts. Reset stands in for power-up and restarts the frame at its first header bit.

Two parity variants exist. In the standard variant, every row parity bit is even. In the phase-shift variant, the first two rows carry odd parity. In both variants, column parity is even over all ten rows.

The sequencer is a four-state machine:
- `ST_HDR` sends the header ones.
- `ST_ROW` walks the ten rows, four data slots and then a parity slot for each row.
- `ST_COL` sends the column parity bits.
- `ST_STOP` sends the zero stop bit.

State changes happen only on the last cycle of a bit period. The machine has four transitions:
- HDR_DONE: after the ninth header bit, `ST_HDR` goes to `ST_ROW`.
- ROWS_DONE: after the parity slot of row ten, `ST_ROW` goes to `ST_COL`.
- COL_DONE: after the fourth column bit, `ST_COL` goes to `ST_STOP`.
- WRAP: `ST_STOP` returns to `ST_HDR` with no gap.

Top module: `idf_stream`

## Requirements
- R1: Bit positions 0 to 63 of the frame, in send order, are: positions 0-8 header; positions 9-58 ten rows of five bits (four data bits, then that row's parity bit); positions 59-62 column parity for columns 0 to 3; position 63 stop.
- R2: All nine header bits are 1 and the stop bit is 0.
- R3: With `psk_mode`=0, every row parity bit makes its row's four data bits plus parity an even number of ones.
- R4: Column parity bit c is even parity over data bit c of all ten rows, in both variants.
- R5: After frame position 63, the next bit period sends position 0 again, with no idle period between frames.
- R6: `rate_sel` 2'b00 gives 64 cycles per bit, 2'b01 gives 32, and 2'b10 or 2'b11 gives 16. `bit_strobe` is 1 exactly in the first cycle of each bit period.
- R7: With `psk_mode`=1, rows 0 and 1 carry odd parity (the five bits hold an odd number of ones) and rows 2 to 9 carry even parity.
- R8: Reset (`rst`=1, synchronous) clears the bit position and the period count. While reset is held, and in the first cycle after it is released, `ser_bit` is 1 (header bit 0) and `bit_strobe` is 1.
- R9: Data bit c of row r is `id_in[39-4*r-c]`. Within a row, c=0 is sent first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-derived clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| id_in | input | 40 | Identifier, row 0 column 0 in bit 39 |
| rate_sel | input | 2 | Data period select: 00=64, 01=32, 1x=16 cycles |
| psk_mode | input | 1 | 1 selects the phase-shift parity variant |
| ser_bit | output | 1 | Current frame bit |
| bit_strobe | output | 1 | High in the first cycle of each bit period |

## Verification
The in-line assertions check the following on every cycle:
- header ones and the stop zero;
- that the sequencer holds its state between period ends;
- that a strobe follows every period end;
- the wrap from stop to header;
- the reset restart;
- the overall even balance of the column parity against the identifier.

Only the bench's scenarios can show that each row and column parity bit lands in its exact slot with the right polarity for each variant. The same holds for the identifier bit order and the exact period length at each rate setting. For these, the bench compares both outputs on every clock against a behavioural frame model, over several identifiers, all rate settings and both variants.

// File: rtl/idf_pkg.sv
package idf_pkg;

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_ROW  = 2'd1,
        ST_COL  = 2'd2,
        ST_STOP = 2'd3
    } seq_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/idf_timer.sv
module idf_timer #(
    parameter int BASE_DIV = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate_sel,
    output logic       tick,
    output logic       strobe
);
    localparam int MAX_DIV = BASE_DIV * 4;
    localparam int CNT_W   = $clog2(MAX_DIV);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    always_comb begin
        unique case (rate_sel)
            2'b00:   last = CNT_W'(MAX_DIV - 1);
            2'b01:   last = CNT_W'(MAX_DIV / 2 - 1);
            default: last = CNT_W'(BASE_DIV - 1);
        endcase
    end

    // >= keeps the counter safe when the period shrinks mid-bit
    assign tick   = (cnt >= last);
    assign strobe = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    assert_tick_then_strobe_R6: assert property (
        @(posedge clk) disable iff (rst) tick |=> strobe);

    assert_strobe_after_reset_R8: assert property (
        @(posedge clk) disable iff (rst) $fell(rst) |-> strobe);

    assert_strobe_is_single_R6: assert property (
        @(posedge clk) disable iff (rst) (strobe && !tick) |=> !strobe);

endmodule

// File: rtl/idf_parity.sv
module idf_parity #(
    parameter int ROWS     = 10,
    parameter int COLS     = 4,
    parameter int ODD_ROWS = 2
) (
    input  logic [ROWS*COLS-1:0] id,
    input  logic                 psk_mode,
    output logic [ROWS-1:0]      row_par,
    output logic [COLS-1:0]      col_par
);
    localparam int ID_W = ROWS * COLS;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam bit ODD = (r < ODD_ROWS);
        assign row_par[r] = (^id[ID_W-1-r*COLS -: COLS]) ^ (psk_mode & ODD);
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        always_comb begin
            col_par[c] = 1'b0;
            for (int r = 0; r < ROWS; r++)
                col_par[c] = col_par[c] ^ id[ID_W-1-r*COLS-c];
        end
    end

    // R4: the column bits balance the whole identifier to an even count
    always_comb begin
        if (!$isunknown(id) && !$isunknown(col_par))
            assert_col_balance_R4: assert ((^{col_par, id}) == 1'b0);
    end

endmodule

// File: rtl/idf_seq.sv
module idf_seq
    import idf_pkg::*;
#(
    parameter int ROWS    = 10,
    parameter int COLS    = 4,
    parameter int HDR_LEN = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [ROWS*COLS-1:0] id,
    input  logic [ROWS-1:0]      row_par,
    input  logic [COLS-1:0]      col_par,
    output logic                 ser_bit
);
    localparam int ID_W  = ROWS * COLS;
    localparam int SUB_W = $clog2(max2(HDR_LEN, COLS + 1));
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);

    seq_state_t       state, state_nx;
    logic [SUB_W-1:0] sub, sub_nx;
    logic [ROW_W-1:0] row, row_nx;

    logic [0:COLS-1] row_data [ROWS];
    for (genvar r = 0; r < ROWS; r++) begin : g_split
        assign row_data[r] = id[ID_W-1-r*COLS -: COLS];
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HDR;
            sub   <= '0;
            row   <= '0;
        end else if (tick) begin
            state <= state_nx;
            sub   <= sub_nx;
            row   <= row_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        sub_nx   = sub + 1'b1;
        row_nx   = row;
        unique case (state)
            ST_HDR: if (sub == SUB_W'(HDR_LEN - 1)) begin   // HDR_DONE
                state_nx = ST_ROW;
                sub_nx   = '0;
                row_nx   = '0;
            end
            ST_ROW: if (sub == SUB_W'(COLS)) begin
                sub_nx = '0;
                if (row == ROW_W'(ROWS - 1)) state_nx = ST_COL;  // ROWS_DONE
                else                         row_nx   = row + 1'b1;
            end
            ST_COL: if (sub == SUB_W'(COLS - 1)) begin      // COL_DONE
                state_nx = ST_STOP;
                sub_nx   = '0;
            end
            ST_STOP: begin                                  // WRAP
                state_nx = ST_HDR;
                sub_nx   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_HDR:  ser_bit = 1'b1;
            ST_ROW:  ser_bit = (sub == SUB_W'(COLS)) ? row_par[row]
                                                     : row_data[row][sub[COL_W-1:0]];
            ST_COL:  ser_bit = col_par[sub[COL_W-1:0]];
            ST_STOP: ser_bit = 1'b0;
        endcase
    end

    assert_hdr_ones_R2: assert property (
        @(posedge clk) disable iff (rst) (state == ST_HDR) |-> ser_bit);

    assert_stop_zero_R2: assert property (
        @(posedge clk) disable iff (rst) (state == ST_STOP) |-> !ser_bit);

    assert_hold_in_period_R6: assert property (
        @(posedge clk) disable iff (rst)
        !tick |=> ($stable(state) && $stable(sub) && $stable(row)));

    assert_wrap_no_gap_R5: assert property (
        @(posedge clk) disable iff (rst)
        (state == ST_STOP && tick) |=> (state == ST_HDR && sub == '0));

    assert_restart_R8: assert property (
        @(posedge clk) disable iff (rst)
        $fell(rst) |-> (state == ST_HDR && sub == '0 && ser_bit));

    assert_rows_bounded_R1: assert property (
        @(posedge clk) disable iff (rst)
        (state == ST_ROW) |-> (row < ROW_W'(ROWS) && sub <= SUB_W'(COLS)));

endmodule

// File: rtl/idf_stream.sv
module idf_stream #(
    parameter int ROWS     = 10,
    parameter int COLS     = 4,
    parameter int HDR_LEN  = 9,
    parameter int BASE_DIV = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ROWS*COLS-1:0] id_in,
    input  logic [1:0]           rate_sel,
    input  logic                 psk_mode,
    output logic                 ser_bit,
    output logic                 bit_strobe
);
    logic            tick;
    logic [ROWS-1:0] row_par;
    logic [COLS-1:0] col_par;

    idf_timer #(.BASE_DIV(BASE_DIV)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .rate_sel(rate_sel),
        .tick    (tick),
        .strobe  (bit_strobe)
    );

    idf_parity #(.ROWS(ROWS), .COLS(COLS), .ODD_ROWS(2)) u_parity (
        .id      (id_in),
        .psk_mode(psk_mode),
        .row_par (row_par),
        .col_par (col_par)
    );

    idf_seq #(.ROWS(ROWS), .COLS(COLS), .HDR_LEN(HDR_LEN)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .id     (id_in),
        .row_par(row_par),
        .col_par(col_par),
        .ser_bit(ser_bit)
    );

endmodule

// File: tb/tb_idf_stream.sv
module tb_idf_stream;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [39:0] id_in = 40'hA5_3C_96_0F_E1;
    logic [1:0]  rate_sel = 2'b00;
    logic        psk_mode = 1'b0;
    logic        ser_bit, bit_strobe;

    int n_chk = 0, n_fail = 0;
    int m_cnt = 0, m_idx = 0;
    bit wrapped = 0, done = 0;

    idf_stream dut (
        .clk(clk), .rst(rst), .id_in(id_in), .rate_sel(rate_sel),
        .psk_mode(psk_mode), .ser_bit(ser_bit), .bit_strobe(bit_strobe)
    );

    always #10 clk = ~clk;

    function automatic int period_of(input logic [1:0] s);
        if (s == 2'b00) return 64;
        if (s == 2'b01) return 32;
        return 16;
    endfunction

    // behavioural frame: bit k is the k-th bit sent (R1, R9)
    function automatic logic [63:0] build(input logic [39:0] id, input logic psk);
        logic [63:0] f = '0;
        for (int k = 0; k < 9; k++) f[k] = 1'b1;
        for (int r = 0; r < 10; r++) begin
            int ones = 0;
            for (int c = 0; c < 4; c++) begin
                f[9 + 5*r + c] = id[39 - 4*r - c];
                ones += int'(id[39 - 4*r - c]);
            end
            if (psk && r < 2) f[9 + 5*r + 4] = (ones % 2 == 0);
            else              f[9 + 5*r + 4] = (ones % 2 == 1);
        end
        for (int c = 0; c < 4; c++) begin
            int ones = 0;
            for (int r = 0; r < 10; r++) ones += int'(id[39 - 4*r - c]);
            f[59 + c] = (ones % 2 == 1);
        end
        f[63] = 1'b0;
        return f;
    endfunction

    function automatic string tag_of(input int k, input logic psk, input logic rs, input bit wr);
        int j, r, c;
        if (rs) return "R8";
        if (k == 0 && wr) return "R5";
        if (k < 9 || k == 63) return "R2";
        if (k >= 59) return "R4";
        j = k - 9; r = j / 5; c = j % 5;
        if (c == 4) return (psk && r < 2) ? "R7" : "R3";
        return "R9 (R1 order)";
    endfunction

    task automatic check(input logic got, input logic exp, input string tag, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b (frame pos %0d, count %0d)",
                     tag, what, got, exp, m_idx, m_cnt);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_idx = 0; wrapped = 0;
        end else if (m_cnt >= period_of(rate_sel) - 1) begin
            m_cnt = 0;
            if (m_idx == 63) begin m_idx = 0; wrapped = 1; end
            else m_idx++;
        end else begin
            m_cnt++;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            logic [63:0] fr;
            fr = build(id_in, psk_mode);
            check(ser_bit, fr[m_idx], tag_of(m_idx, psk_mode, rst, wrapped), "ser_bit");
            check(bit_strobe, (m_cnt == 0), rst ? "R8" : "R6", "bit_strobe");
        end
    end

    task automatic run_case(input logic [39:0] id, input logic [1:0] rs,
                            input logic psk, input int frames);
        @(posedge clk); #2;
        rst = 1'b1; id_in = id; rate_sel = rs; psk_mode = psk;
        repeat (2) @(posedge clk);
        #2 rst = 1'b0;
        repeat (frames * 64 * period_of(rs) + 10) @(posedge clk);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired (all requirements)");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // standard variant, slowest rate, two frames to cover the wrap (R5, R6)
        repeat (2 * 64 * 64 + 10) @(posedge clk);
        run_case(40'h12_34_56_78_9A, 2'b01, 1'b0, 2);   // R3, R9 at 32 cycles
        run_case(40'h0F_F0_00_FF_55, 2'b10, 1'b1, 2);   // R7 phase-shift parity
        run_case(40'hFF_FF_FF_FF_FF, 2'b11, 1'b1, 1);   // R7, R4 all ones
        run_case(40'h00_00_00_00_00, 2'b00, 1'b0, 1);   // R3, R4 all zeros
        run_case(40'h00_00_00_00_00, 2'b10, 1'b1, 1);   // R7 odd rows from zero data
        run_case(40'h80_00_00_00_01, 2'b01, 1'b0, 1);   // R9 end bits
        done = 1;
        summary();
        $finish;
    end

endmodule